// File: doc/BRIEF.md
# Gear-Down Command Phase Tracker

This block follows, on the memory side, the rate at which the control lines (chip select, clock enable, termination enable) are captured. After reset it runs at full rate (1N), and every clock edge is a valid capture edge. To move to half rate (2N), software first writes the gear-down field of the gear-control mode register with a 1. This arms the tracker. The first chip-select pulse that follows, and that is not itself part of a mode-register write, is the sync pulse. That pulse fixes which clock parity is used for capture. Half-rate capture starts a programmable number of cycles after the sync pulse. Until then, every edge remains a capture edge.

Entering self refresh always returns the tracker to 1N and discards any armed or pending state. Any other attempt to leave 2N is reported as a fault. While the tracker is in 2N, it also checks the programmed latency values. A sticky violation flag collects three kinds of fault: a sync pulse at an odd distance from the arming write, a write that clears the gear-down field while 2N is pending or active, and latencies that break the 2N rules. Mode-register decoding is done upstream. The tracker receives only a write strobe, the register index and the value of the gear-down field.

Top module: `gear_phase_tracker`

## Requirements
- R1: After reset, mode_2n is 0, sample_en is 1 and violation is 0.
- R2: Whenever mode_2n is 0, sample_en is 1 in every cycle. This includes the time while armed and while a 2N switch is pending.
- R3: A write (mrw_valid=1) with mrw_sel=3 and mrw_gear=1, made while in 1N and outside self refresh, arms the tracker. A later cs_pulse with mrw_valid=0 is the sync pulse. A cs_pulse with no arming has no effect.
- R4: If the sync pulse is in cycle t, mode_2n rises in cycle t+N, where N is gear_delay sampled in cycle t, with 0 treated as 1. Later changes to gear_delay do not move the switch point.
- R5: In 2N, sample_en is 1 exactly in cycles t+2k and 0 in cycles t+2k+1.
- R6: A sync pulse an odd number of cycles after the most recent arming write sets violation in the next cycle. The 2N switch still proceeds.
- R7: sr_enter=1 makes mode_2n 0 and sample_en 1 from the next cycle, and discards any armed or pending state.
- R8: From an sr_enter cycle up to and including the cycle in which sr_exit=1, mode-register writes and cs_pulse are ignored.
- R9: A write with mrw_sel=3 and mrw_gear=0 while 2N is pending or active sets violation in the next cycle. It does not leave 2N.
- R10: In 2N, violation is set in the next cycle if any of the following holds: lat_cl, lat_wr or lat_cwl is odd, or lat_al is nonzero and not equal to lat_cl-2.
- R11: Once set, violation stays 1 until reset.
- R12: A write with mrw_sel=3 and mrw_gear=0 while armed disarms the tracker without a violation. A later cs_pulse then has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrw_valid | input | 1 | Decoded mode-register write in this cycle |
| mrw_sel | input | MR_SEL_W | Index of the written mode register |
| mrw_gear | input | 1 | Value written to the gear-down field |
| cs_pulse | input | 1 | Chip-select pulse seen at full rate |
| sr_enter | input | 1 | Self-refresh entry command |
| sr_exit | input | 1 | Self-refresh exit |
| gear_delay | input | CNT_W | Cycles from sync pulse to 2N capture |
| lat_cl | input | LAT_W | Programmed CAS latency, in clocks |
| lat_wr | input | LAT_W | Programmed write recovery / read-to-precharge, in clocks |
| lat_cwl | input | LAT_W | Programmed CAS write latency, in clocks |
| lat_al | input | LAT_W | Programmed additive latency, in clocks (0 = off) |
| sample_en | output | 1 | Control lines are captured on this edge |
| mode_2n | output | 1 | Half-rate capture is active |
| violation | output | 1 | Sticky protocol fault |

## Verification
The bench builds the tracker with its default parameters: a 3-bit register index, an 8-bit delay count and 6-bit latency fields. gear_delay values from 0 to 6 therefore reach every switch point, both even and odd, including the zero-means-one case, in a few cycles. The 6-bit latency fields leave room to pick lat_cl above 2, so the rule that lat_al equals lat_cl-2 can be tested without wraparound. Random segments mix arming, sync and self-refresh traffic, so parity relations between arm, sync and capture edges of both kinds appear repeatedly.

// File: rtl/gear_pkg.sv
package gear_pkg;

  typedef enum logic [1:0] {
    GS_1N    = 2'd0,
    GS_ARMED = 2'd1,
    GS_PEND  = 2'd2,
    GS_2N    = 2'd3
  } gear_state_e;

  // Index of the register holding the gear-down field.
  localparam int GEAR_MR_IDX = 3;

endpackage

// File: rtl/gear_phase_ref.sv
// Free-running parity toggle with captured arm and sync phases.
module gear_phase_ref (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_arm,
  input  logic cap_sync,
  output logic even_gap,
  output logic on_phase
);

  logic tog;
  logic arm_par;
  logic sync_par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog      <= 1'b0;
      arm_par  <= 1'b0;
      sync_par <= 1'b0;
    end else begin
      tog <= ~tog;
      if (cap_arm)  arm_par  <= tog;
      if (cap_sync) sync_par <= tog;
    end
  end

  // Equal parity means an even number of cycles since the arm.
  assign even_gap = (tog == arm_par);
  assign on_phase = (tog == sync_par);

endmodule

// File: rtl/gear_delay_cnt.sv
// Down-counter for the sync-to-2N delay.
module gear_delay_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CNT_W'(1));

endmodule

// File: rtl/gear_lat_check.sv
// Latency legality rules that apply while running at half rate.
module gear_lat_check #(
  parameter int LAT_W = 6
) (
  input  logic [LAT_W-1:0] cl,
  input  logic [LAT_W-1:0] wr,
  input  logic [LAT_W-1:0] cwl,
  input  logic [LAT_W-1:0] al,
  output logic             legal
);

  localparam int EXT_W = LAT_W + 1;

  function automatic logic al_fits(input logic [LAT_W-1:0] c,
                                   input logic [LAT_W-1:0] a);
    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] c_ext;
    a_ext = {1'b0, a};
    c_ext = {1'b0, c};
    return (a == '0) || ((a_ext + EXT_W'(2)) == c_ext);
  endfunction

  function automatic logic all_even(input logic [LAT_W-1:0] x,
                                    input logic [LAT_W-1:0] y,
                                    input logic [LAT_W-1:0] z);
    return !(x[0] | y[0] | z[0]);
  endfunction

  assign legal = all_even(cl, wr, cwl) && al_fits(cl, al);

endmodule

// File: rtl/gear_phase_tracker.sv
module gear_phase_tracker
  import gear_pkg::*;
#(
  parameter int MR_SEL_W = 3,
  parameter int CNT_W    = 8,
  parameter int LAT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mrw_valid,
  input  logic [MR_SEL_W-1:0] mrw_sel,
  input  logic                mrw_gear,
  input  logic                cs_pulse,
  input  logic                sr_enter,
  input  logic                sr_exit,
  input  logic [CNT_W-1:0]    gear_delay,
  input  logic [LAT_W-1:0]    lat_cl,
  input  logic [LAT_W-1:0]    lat_wr,
  input  logic [LAT_W-1:0]    lat_cwl,
  input  logic [LAT_W-1:0]    lat_al,
  output logic                sample_en,
  output logic                mode_2n,
  output logic                violation
);

  localparam logic [MR_SEL_W-1:0] GEAR_SEL = MR_SEL_W'(GEAR_MR_IDX);

  gear_state_e st, st_n;
  logic        in_sr;
  logic        viol_q;

  // Named internal events (also observed by the bound checker).
  logic live;
  logic gear_hit, gear_set, gear_clr;
  logic arm_evt, disarm_evt, sync_evt, sync_odd_evt, unsafe_exit_evt;
  logic lat_legal, lat_bad;
  logic short_gear, cnt_expire;
  logic even_gap, on_phase;

  assign live       = !sr_enter && !in_sr;
  assign gear_hit   = mrw_valid && (mrw_sel == GEAR_SEL);
  assign gear_set   = gear_hit && mrw_gear;
  assign gear_clr   = gear_hit && !mrw_gear;
  assign arm_evt    = live && gear_set && ((st == GS_1N) || (st == GS_ARMED));
  assign disarm_evt = live && gear_clr && (st == GS_ARMED);
  assign sync_evt   = live && (st == GS_ARMED) && cs_pulse && !mrw_valid;
  assign sync_odd_evt    = sync_evt && !even_gap;
  assign unsafe_exit_evt = live && gear_clr && ((st == GS_PEND) || (st == GS_2N));
  assign lat_bad    = (st == GS_2N) && !lat_legal;
  assign short_gear = (gear_delay <= CNT_W'(1));

  gear_phase_ref u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_arm  (arm_evt),
    .cap_sync (sync_evt),
    .even_gap (even_gap),
    .on_phase (on_phase)
  );

  gear_delay_cnt #(.CNT_W(CNT_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sync_evt && !short_gear),
    .load_val (gear_delay - CNT_W'(1)),
    .expire   (cnt_expire)
  );

  gear_lat_check #(.LAT_W(LAT_W)) u_lat (
    .cl    (lat_cl),
    .wr    (lat_wr),
    .cwl   (lat_cwl),
    .al    (lat_al),
    .legal (lat_legal)
  );

  always_comb begin
    st_n = st;
    if (sr_enter) begin
      st_n = GS_1N;
    end else if (!in_sr) begin
      unique case (st)
        GS_1N:    if (arm_evt) st_n = GS_ARMED;
        GS_ARMED: begin
          if (disarm_evt)    st_n = GS_1N;
          else if (sync_evt) st_n = short_gear ? GS_2N : GS_PEND;
        end
        GS_PEND:  if (cnt_expire) st_n = GS_2N;
        default:  st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= GS_1N;
      in_sr  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      st <= st_n;
      if (sr_enter)     in_sr <= 1'b1;
      else if (sr_exit) in_sr <= 1'b0;
      if (sync_odd_evt || unsafe_exit_evt || lat_bad) viol_q <= 1'b1;
    end
  end

  assign mode_2n   = (st == GS_2N);
  assign sample_en = mode_2n ? on_phase : 1'b1;
  assign violation = viol_q;

endmodule

// File: rtl/gear_phase_tracker_chk.sv
module gear_phase_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_en,
  input logic mode_2n,
  input logic violation,
  input logic sr_enter,
  input logic sync_odd_evt,
  input logic unsafe_exit_evt,
  input logic lat_bad
);

  // R2
  full_rate_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_2n |-> sample_en);

  // R5
  half_rate_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_2n && $past(mode_2n)) |-> (sample_en != $past(sample_en)));

  // R6
  odd_sync_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_odd_evt |=> violation);

  // R7
  sr_resets_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |=> !mode_2n);

  // R9
  unsafe_exit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsafe_exit_evt |=> violation);

  // R9
  unsafe_exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unsafe_exit_evt && mode_2n) |=> mode_2n);

  // R10
  latency_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_bad |=> violation);

  // R11
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

endmodule

bind gear_phase_tracker gear_phase_tracker_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .sample_en       (sample_en),
  .mode_2n         (mode_2n),
  .violation       (violation),
  .sr_enter        (sr_enter),
  .sync_odd_evt    (sync_odd_evt),
  .unsafe_exit_evt (unsafe_exit_evt),
  .lat_bad         (lat_bad)
);

// File: tb/gear_phase_tracker_tb_top.sv
module gear_phase_tracker_tb_top;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mrw_valid, mrw_gear, cs_pulse, sr_enter, sr_exit;
  logic [2:0] mrw_sel;
  logic [7:0] gear_delay;
  logic [5:0] lat_cl, lat_wr, lat_cwl, lat_al;
  logic       sample_en, mode_2n, violation;

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state
  int cyc;
  bit m_sr, m_armed, m_synced, m_viol;
  int m_arm_c, m_sync_c, m_n;

  always #(PERIOD/2) clk = ~clk;

  gear_phase_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .mrw_valid(mrw_valid), .mrw_sel(mrw_sel),
    .mrw_gear(mrw_gear), .cs_pulse(cs_pulse), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .gear_delay(gear_delay), .lat_cl(lat_cl),
    .lat_wr(lat_wr), .lat_cwl(lat_cwl), .lat_al(lat_al),
    .sample_en(sample_en), .mode_2n(mode_2n), .violation(violation)
  );

  function automatic bit lat_fine(int cl, int wr, int cwl, int al);
    if ((cl % 2) != 0 || (wr % 2) != 0 || (cwl % 2) != 0) return 1'b0;
    return (al == 0) || (al + 2 == cl);
  endfunction

  function automatic bit exp_mode();
    return m_synced && (cyc >= m_sync_c + m_n);
  endfunction

  function automatic bit exp_sample();
    if (!exp_mode()) return 1'b1;
    return ((cyc - m_sync_c) % 2) == 0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b cyc=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_step(bit w, int sel, bit g, bit cs, bit sre, bit srx);
    if (exp_mode() && !lat_fine(lat_cl, lat_wr, lat_cwl, lat_al)) m_viol = 1;
    if (sre) begin
      m_sr = 1; m_armed = 0; m_synced = 0;
    end else if (m_sr) begin
      if (srx) m_sr = 0;
    end else if (w && sel == 3) begin
      if (g) begin
        if (!m_synced) begin m_armed = 1; m_arm_c = cyc; end
      end else begin
        if (m_armed) m_armed = 0;
        if (m_synced) m_viol = 1;
      end
    end else if (!w && cs && m_armed) begin
      m_synced = 1; m_armed = 0; m_sync_c = cyc;
      m_n = (gear_delay < 1) ? 1 : int'(gear_delay);
      if (((cyc - m_arm_c) % 2) != 0) m_viol = 1;
    end
  endtask

  task automatic compare();
    check("R4 mode_2n", mode_2n, exp_mode());
    check(exp_mode() ? "R5 sample_en" : "R2 sample_en", sample_en, exp_sample());
    check("R11 violation", violation, m_viol);
  endtask

  task automatic tick(bit w, int sel, bit g, bit cs, bit sre, bit srx);
    mrw_valid = w; mrw_sel = sel[2:0]; mrw_gear = g;
    cs_pulse = cs; sr_enter = sre; sr_exit = srx;
    model_step(w, sel, g, cs, sre, srx);
    @(posedge clk);
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
  endtask

  task automatic set_lat(int cl, int wr, int cwl, int al);
    lat_cl = cl[5:0]; lat_wr = wr[5:0]; lat_cwl = cwl[5:0]; lat_al = al[5:0];
  endtask

  task automatic do_reset();
    rst_n = 0;
    mrw_valid = 0; mrw_sel = 0; mrw_gear = 0; cs_pulse = 0;
    sr_enter = 0; sr_exit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc = 0; m_sr = 0; m_armed = 0; m_synced = 0; m_viol = 0;
    m_arm_c = 0; m_sync_c = 0; m_n = 1;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    gear_delay = 8'd4;
    set_lat(16, 12, 12, 0);
    do_reset();

    // R1 reset state
    check("R1 sample_en", sample_en, 1'b1);
    check("R1 mode_2n", mode_2n, 1'b0);
    check("R1 violation", violation, 1'b0);

    // R3 R4 R5: arm, even-spaced sync, delay 4
    tick(1, 3, 1, 1, 0, 0);
    idle(1);
    tick(0, 0, 0, 1, 0, 0);          // sync in cycle t, now cycle t+1
    gear_delay = 8'd1;                // must not move the switch (R4)
    idle(2);                          // cycle t+3
    check("R4 still 1N at t+3", mode_2n, 1'b0);
    check("R2 sample while pending", sample_en, 1'b1);
    idle(1);                          // cycle t+4
    check("R3 armed sync reaches 2N", mode_2n, 1'b1);
    check("R5 sample on sync parity", sample_en, 1'b1);
    check("R6 even gap no fault", violation, 1'b0);
    idle(1);
    check("R5 no sample off parity", sample_en, 1'b0);

    // R10 odd CL in 2N, then R11 stickiness
    set_lat(15, 12, 12, 0);
    idle(1);
    check("R10 odd CL flags", violation, 1'b1);
    set_lat(16, 12, 12, 0);
    idle(3);
    check("R11 flag holds", violation, 1'b1);

    // R10 bad additive latency
    do_reset();
    gear_delay = 8'd2;
    set_lat(18, 14, 10, 16);
    tick(1, 3, 1, 1, 0, 0); idle(1); tick(0, 0, 0, 1, 0, 0); idle(3);
    check("R10 AL = CL-2 accepted", violation, 1'b0);
    set_lat(18, 14, 10, 15);
    idle(1);
    check("R10 AL mismatch flags", violation, 1'b1);

    // R6 odd-spaced sync still switches
    do_reset();
    gear_delay = 8'd0;
    set_lat(16, 12, 12, 0);
    tick(1, 3, 1, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0);
    check("R6 odd gap flags", violation, 1'b1);
    check("R6 switch proceeds", mode_2n, 1'b1);

    // R9 R7 R8
    do_reset();
    gear_delay = 8'd2;
    tick(1, 3, 1, 1, 0, 0); idle(1); tick(0, 0, 0, 1, 0, 0); idle(2);
    check("R9 setup in 2N", mode_2n, 1'b1);
    tick(1, 3, 0, 1, 0, 0);
    check("R9 clear flags", violation, 1'b1);
    check("R9 stays 2N", mode_2n, 1'b1);
    tick(0, 0, 0, 0, 1, 0);
    check("R7 back to 1N", mode_2n, 1'b0);
    check("R7 sample every edge", sample_en, 1'b1);
    tick(1, 3, 1, 1, 0, 0); idle(1); tick(0, 0, 0, 1, 0, 0);
    tick(0, 0, 0, 0, 0, 1); idle(4);
    check("R8 writes in SR ignored", mode_2n, 1'b0);
    tick(0, 0, 0, 1, 0, 0); idle(4);
    check("R3 unarmed cs no effect", mode_2n, 1'b0);

    // R12 disarm
    do_reset();
    tick(1, 3, 1, 1, 0, 0);
    tick(1, 3, 0, 1, 0, 0);
    idle(1);
    tick(0, 0, 0, 1, 0, 0); idle(4);
    check("R12 disarmed stays 1N", mode_2n, 1'b0);
    check("R12 no fault", violation, 1'b0);

    // Random segments
    for (int s = 0; s < 10; s++) begin
      do_reset();
      gear_delay = 8'($urandom_range(0, 6));
      if ($urandom_range(0, 3) == 0) set_lat(17, 12, 11, 3);
      else set_lat(16, 12, 12, ($urandom_range(0, 1) == 1) ? 14 : 0);
      for (int i = 0; i < 400; i++) begin
        bit w, g, cs, sre, srx;
        int sel;
        w   = ($urandom_range(0, 99) < 6);
        sel = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 7)) : 3;
        g   = ($urandom_range(0, 3) != 0);
        cs  = ($urandom_range(0, 99) < 15);
        sre = ($urandom_range(0, 99) < 2);
        srx = ($urandom_range(0, 99) < 20);
        tick(w, sel, g, cs, sre, srx);
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule